// File: doc/BRIEF.md
# Multi-Select Serial Peripheral Master

This block is a register-driven SPI controller that runs the serial clock, the outgoing data line, the incoming data line and a bus of chip-select lines toward several peripherals. A host first loads a configuration word through `cfg_wr`. The word holds the mode flags, a clock divider, a transfer length and a mask of peripherals. The host then writes a data word through `dat_wr`, and that write launches one transfer. Any number of peripherals may be selected at once through the mask.

The host can chain transfers under a single chip-select assertion, so that an opcode and its payload reach the peripherals as one transaction. Chip select is released only after a transfer whose end flag is set. When the input flag is set, the word shifted in during the transfer is presented as a one-cycle input event at completion. The flags also select the clock idle level, the clock phase, the bit order, the chip-select polarity and a 3-wire mode in which the data-out pin also receives. An offline flag releases every pin enable.

Top module: `spi_xfer_master`

## Requirements
- R1: The serial clock period is N = `cfg_div` + 2 system cycles, so N runs from 2 to 257. Each bit spends its first N − floor(N/2) cycles at the active (non-idle) level and the remaining floor(N/2) cycles at the idle level.
- R2: A transfer begins in the cycle after an accepted data write. The clock stays idle for floor(N/2) cycles before the first leading edge. `busy` is high for floor(N/2) + L·N cycles and then falls, one idle half-period after the last clock edge.
- R3: The transfer length L is `cfg_len` + 1 bits, covering 1 to 32. The first L bits of the data word are sent, and an L-bit word is received.
- R4: From the first cycle of a transfer, every line whose mask bit is set is at its active level. All other lines stay inactive. The active level is high when flag bit 6 is 1 and low otherwise. At completion, chip select is released only if flag bit 0 (end) was set. Otherwise it stays asserted through the idle gap and into the next transfer.
- R5: The idle level of the serial clock equals flag bit 2. It takes effect in the cycle after the configuration write.
- R6: With flag bit 3 clear, the incoming line is sampled on the leading clock edge and the outgoing bit changes on the trailing edge. With flag bit 3 set, the outgoing bit changes on the leading edge (except for the first bit) and sampling happens on the trailing edge.
- R7: With flag bit 4 set, bits travel least significant first in both directions. Otherwise they travel most significant first. The received word is right-aligned in both orders.
- R8: With flag bit 1 (input) set, `rd_valid` pulses for one cycle, in the cycle `busy` falls, with the received word on `rd_data`. With the flag clear, `rd_valid` never rises.
- R9: With flag bit 5 set (3-wire), received bits are taken from `mosi_i` instead of `miso_i`. If the input flag is also set, `mosi_oe` is low for the transfer.
- R10: With flag bit 7 (offline) set, `sck_oe`, `mosi_oe` and `cs_oe` are all low.
- R11: A data write while `busy` is high is ignored and raises `wr_err` for one cycle in the next cycle. A configuration write while busy is ignored.
- R12: After reset the block is idle: `busy` is low, the serial clock is low, all chip selects are high and all output enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_flags | input | 8 | Mode flags: 0 end, 1 input, 2 clock idle level, 3 clock phase, 4 LSB first, 5 3-wire, 6 chip-select active high, 7 offline |
| cfg_div | input | DIV_W | Clock divider minus two |
| cfg_len | input | LEN_W | Transfer length minus one |
| cfg_cs | input | NCS | Peripheral select mask |
| dat_wr | input | 1 | Data write strobe; starts a transfer |
| dat_in | input | DATA_W | Word to send |
| busy | output | 1 | Transfer in progress |
| wr_err | output | 1 | Data write rejected while busy |
| rd_valid | output | 1 | Received word event |
| rd_data | output | DATA_W | Received word |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock enable |
| mosi_o | output | 1 | Outgoing data |
| mosi_oe | output | 1 | Outgoing data enable |
| mosi_i | input | 1 | Data pin read-back, used in 3-wire mode |
| miso_i | input | 1 | Incoming data |
| cs_o | output | NCS | Chip-select lines |
| cs_oe | output | 1 | Chip-select enable |

## Verification
The hardest situation to reach is a chained transaction whose configuration changes in the idle gap between two transfers while chip select must hold steady. The bench sends an 8-bit opcode without the end flag to two peripherals. It then rewrites the configuration with end and input set and issues a 32-bit payload, and it checks the select lines in every cycle of the gap. A second hard case is a collision, where a data write and a configuration write both arrive mid-transfer. The stimulus injects both at a chosen cycle inside a running transfer. The per-cycle model then confirms that the clock, the selects and the received word do not change.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
    localparam int FLAG_W  = 8;
    localparam int F_END   = 0;
    localparam int F_INP   = 1;
    localparam int F_CPOL  = 2;
    localparam int F_CPHA  = 3;
    localparam int F_LSB   = 4;
    localparam int F_HALF  = 5;
    localparam int F_CSPOL = 6;
    localparam int F_OFF   = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_TRAIL
    } phase_e;
endpackage

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
    parameter int NCS = 4
) (
    input  logic           act,
    input  logic           pol,
    input  logic [NCS-1:0] sel,
    output logic [NCS-1:0] cs
);
    for (genvar g = 0; g < NCS; g++) begin : g_line
        assign cs[g] = (act && sel[g]) ? pol : ~pol;
    end
endmodule

// File: rtl/spi_rx_align.sv
module spi_rx_align #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic [DATA_W-1:0] rx,
    input  logic [LEN_W-1:0]  len,
    input  logic              lsb_first,
    output logic [DATA_W-1:0] word
);
    localparam logic [LEN_W-1:0] TOP = LEN_W'(DATA_W - 1);

    logic [DATA_W-1:0] keep;

    always_comb begin
        keep = {DATA_W{1'b1}} >> (TOP - len);
        word = (lsb_first ? (rx >> (TOP - len)) : rx) & keep;
    end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  NCS    = 4,
    parameter int  DIV_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [FLAG_W-1:0] cfg_flags,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [NCS-1:0]    cfg_cs,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_in,
    output logic              busy,
    output logic              wr_err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic [NCS-1:0]    cs_o,
    output logic              cs_oe
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        phase_e            ph;
        logic [FLAG_W-1:0] flg;
        logic [DIV_W-1:0]  div;
        logic [LEN_W-1:0]  len;
        logic [NCS-1:0]    mask;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  idx;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              cs_act;
        logic              sck;
        logic              rd_vld;
        logic              err;
        logic [DATA_W-1:0] rd;
    } st_t;

    st_t s_q, s_d;

    logic [CNT_W-1:0]  per, h_lo, h_hi;
    logic              in_bit;
    logic [DATA_W-1:0] tx_shift, rx_push, tx_load, rx_word;

    spi_rx_align #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_align (
        .rx        (s_q.rx),
        .len       (s_q.len),
        .lsb_first (s_q.flg[F_LSB]),
        .word      (rx_word)
    );

    spi_cs_drive #(.NCS(NCS)) u_cs (
        .act (s_q.cs_act),
        .pol (s_q.flg[F_CSPOL]),
        .sel (s_q.mask),
        .cs  (cs_o)
    );

    always_comb begin
        per      = {1'b0, s_q.div} + CNT_W'(2);
        h_lo     = per >> 1;
        h_hi     = per - h_lo;
        in_bit   = s_q.flg[F_HALF] ? mosi_i : miso_i;
        tx_shift = s_q.flg[F_LSB] ? (s_q.tx >> 1) : (s_q.tx << 1);
        rx_push  = s_q.flg[F_LSB] ? {in_bit, s_q.rx[DATA_W-1:1]}
                                  : {s_q.rx[DATA_W-2:0], in_bit};
        tx_load  = s_q.flg[F_LSB] ? dat_in
                                  : (dat_in << (LEN_W'(DATA_W - 1) - s_q.len));

        s_d        = s_q;
        s_d.rd_vld = 1'b0;
        s_d.err    = 1'b0;

        unique case (s_q.ph)
            ST_IDLE: begin
                if (dat_wr) begin
                    s_d.ph     = ST_SETUP;
                    s_d.cnt    = h_lo - 1'b1;
                    s_d.idx    = '0;
                    s_d.tx     = tx_load;
                    s_d.rx     = '0;
                    s_d.cs_act = 1'b1;
                    s_d.sck    = s_q.flg[F_CPOL];
                end else if (cfg_wr) begin
                    s_d.flg  = cfg_flags;
                    s_d.div  = cfg_div;
                    s_d.len  = cfg_len;
                    s_d.mask = cfg_cs;
                    s_d.sck  = cfg_flags[F_CPOL];
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = ST_LEAD;
                    s_d.cnt = h_hi - 1'b1;
                    s_d.sck = ~s_q.flg[F_CPOL];
                    if (!s_q.flg[F_CPHA]) s_d.rx = rx_push;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_LEAD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = ST_TRAIL;
                    s_d.cnt = h_lo - 1'b1;
                    s_d.sck = s_q.flg[F_CPOL];
                    if (s_q.flg[F_CPHA]) s_d.rx = rx_push;
                    else                 s_d.tx = tx_shift;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_TRAIL: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.idx == s_q.len) begin
                    s_d.ph     = ST_IDLE;
                    s_d.rd_vld = s_q.flg[F_INP];
                    if (s_q.flg[F_INP]) s_d.rd = rx_word;
                    if (s_q.flg[F_END]) s_d.cs_act = 1'b0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.ph  = ST_LEAD;
                    s_d.cnt = h_hi - 1'b1;
                    s_d.sck = ~s_q.flg[F_CPOL];
                    if (s_q.flg[F_CPHA]) s_d.tx = tx_shift;
                    else                 s_d.rx = rx_push;
                end
            end
            default: s_d.ph = ST_IDLE;
        endcase

        if (dat_wr && s_q.ph != ST_IDLE) s_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.ph != ST_IDLE);
    assign wr_err   = s_q.err;
    assign rd_valid = s_q.rd_vld;
    assign rd_data  = s_q.rd;
    assign sck_o    = s_q.sck;
    assign mosi_o   = s_q.flg[F_LSB] ? s_q.tx[0] : s_q.tx[DATA_W-1];
    assign sck_oe   = ~s_q.flg[F_OFF];
    assign cs_oe    = ~s_q.flg[F_OFF];
    assign mosi_oe  = ~s_q.flg[F_OFF] & ~(s_q.flg[F_HALF] & s_q.flg[F_INP]);

    // R4
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_o));

    // R4
    cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.cs_act) |-> $past(s_q.flg[F_END]));

    // R8
    rd_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(busy) && !busy));

    // R11
    wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(busy));

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == s_q.flg[F_CPOL]));
endmodule

// File: tb/spi_xfer_master_test.sv
`timescale 1ns/1ps
module spi_xfer_master_test;
    localparam int NCS = 4;
    localparam logic [7:0] FE = 8'h01, FI = 8'h02, FCPOL = 8'h04, FCPHA = 8'h08,
                           FLSB = 8'h10, FHALF = 8'h20, FCSP = 8'h40, FOFF = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_flags = '0;
    logic [7:0] cfg_div = '0;
    logic [4:0] cfg_len = '0;
    logic [NCS-1:0] cfg_cs = '0;
    logic dat_wr = 1'b0;
    logic [31:0] dat_in = '0;
    logic busy, wr_err, rd_valid, sck_o, sck_oe, mosi_o, mosi_oe, cs_oe;
    logic [31:0] rd_data;
    logic [NCS-1:0] cs_o;
    logic mosi_i = 1'b0;
    logic miso_i = 1'b0;

    int checks = 0;
    int fails = 0;

    logic [7:0] m_flg = '0;
    logic [7:0] m_div = '0;
    logic [4:0] m_len = '0;
    logic [NCS-1:0] m_mask = '0;
    bit chain_open = 1'b0;

    always #2.5 clk = ~clk;

    spi_xfer_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_flags(cfg_flags),
        .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_cs(cfg_cs),
        .dat_wr(dat_wr), .dat_in(dat_in), .busy(busy), .wr_err(wr_err),
        .rd_valid(rd_valid), .rd_data(rd_data), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_i(miso_i),
        .cs_o(cs_o), .cs_oe(cs_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NCS-1:0] exp_cs(input bit act);
        if (act) return m_flg[6] ? m_mask : ~m_mask;
        return m_flg[6] ? '0 : '1;
    endfunction

    task automatic write_cfg(input logic [7:0] f, input logic [7:0] d,
                             input logic [4:0] l, input logic [NCS-1:0] m);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_flags = f; cfg_div = d; cfg_len = l; cfg_cs = m;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_flg = f; m_div = d; m_len = l; m_mask = m;
    endtask

    task automatic idle_chk(input int k);
        for (int i = 0; i < k; i++) begin
            if (i > 0) @(negedge clk);
            chk("R4 idle select", 32'(cs_o), 32'(exp_cs(chain_open)));
            chk("R5 idle clock", 32'(sck_o), 32'(m_flg[2]));
            chk("R2 idle busy", 32'(busy), 32'd0);
        end
    endtask

    task automatic drive_slave(input bit b, input bit half);
        if (half) begin mosi_i = b;  miso_i = ~b; end
        else      begin miso_i = b;  mosi_i = ~b; end
    endtask

    task automatic run_xfer(input logic [31:0] d, input logic [31:0] sw, input int bump);
        int n = int'(m_div) + 2;
        int h2 = n / 2;
        int h1 = n - h2;
        int L = int'(m_len) + 1;
        int T = h2 + L * n;
        bit cpol = m_flg[2], cpha = m_flg[3], lsb = m_flg[4], half = m_flg[5];
        bit inp = m_flg[1], fin = m_flg[0], off = m_flg[7];
        int idx = 0;
        logic [31:0] lm = 32'((64'd1 << L) - 1);
        @(negedge clk);
        dat_wr = 1'b1; dat_in = d;
        @(negedge clk);
        dat_wr = 1'b0;
        drive_slave(lsb ? sw[0] : sw[L-1], half);
        for (int c = 0; c <= T; c++) begin
            bit e_sck;
            int smp;
            if (c > 0) @(negedge clk);
            dat_wr = 1'b0; cfg_wr = 1'b0;
            if (c < h2 || c == T) e_sck = cpol;
            else e_sck = (((c - h2) % n) < h1) ? ~cpol : cpol;
            chk("R1 clock level", 32'(sck_o), 32'(e_sck));
            chk("R4 select", 32'(cs_o), 32'(exp_cs(c < T || !fin)));
            chk("R2 busy", 32'(busy), 32'(c < T));
            chk("R9 R10 enables", {29'd0, sck_oe, mosi_oe, cs_oe},
                {29'd0, ~off, ~off & ~(half & inp), ~off});
            chk("R8 event", 32'(rd_valid), 32'(c == T && inp));
            chk("R11 reject flag", 32'(wr_err), 32'(bump >= 0 && c == bump + 1));
            if (c == T && inp)
                chk("R3 R7 R8 R9 read word", rd_data, sw & lm);
            smp = cpha ? (h2 + idx * n + h1) : (h2 + idx * n);
            if (idx < L && c == smp) begin
                if (!(half && inp))
                    chk("R6 R7 out bit", 32'(mosi_o), 32'(lsb ? d[idx] : d[L-1-idx]));
                idx++;
                if (idx < L) drive_slave(lsb ? sw[idx] : sw[L-1-idx], half);
            end
            if (c == bump) begin
                dat_wr = 1'b1; dat_in = ~d;
                cfg_wr = 1'b1; cfg_flags = m_flg ^ 8'h1C; cfg_div = 8'd7;
            end
        end
        chain_open = !fin;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy", 32'(busy), 32'd0);
        chk("R12 clock", 32'(sck_o), 32'd0);
        chk("R12 select", 32'(cs_o), 32'hF);
        chk("R12 enables", {29'd0, sck_oe, mosi_oe, cs_oe}, 32'd7);
        chk("R12 event", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        write_cfg(FE, 8'd0, 5'd7, 4'b0001);
        run_xfer(32'hA5, 32'h3C, -1);
        idle_chk(3);

        write_cfg(8'h00, 8'd3, 5'd7, 4'b0110);
        run_xfer(32'h13, 32'hC4, -1);
        idle_chk(4);
        write_cfg(FE | FI, 8'd3, 5'd31, 4'b0110);
        idle_chk(2);
        run_xfer(32'hDEADBEEF, 32'h12345678, -1);
        idle_chk(2);

        write_cfg(FE | FI | FCPOL | FCPHA | FLSB | FCSP, 8'd1, 5'd11, 4'b1001);
        idle_chk(2);
        run_xfer(32'h5A3, 32'hB6E, -1);
        idle_chk(2);

        write_cfg(FE | FI | FCPHA, 8'd2, 5'd4, 4'b0010);
        run_xfer(32'h16, 32'h0B, -1);
        write_cfg(FE | FI | FCPOL, 8'd4, 5'd6, 4'b0001);
        run_xfer(32'h4D, 32'h72, -1);

        write_cfg(FE | FI | FHALF, 8'd0, 5'd15, 4'b0100);
        run_xfer(32'h1234, 32'hBEEF, -1);
        write_cfg(FE | FHALF, 8'd0, 5'd9, 4'b0100);
        run_xfer(32'h2AB, 32'h0, -1);

        write_cfg(FE | FI, 8'd255, 5'd0, 4'b1000);
        run_xfer(32'h1, 32'h1, -1);
        write_cfg(FE | FI | FLSB, 8'd123, 5'd7, 4'b1000);
        run_xfer(32'hC3, 32'h81, -1);

        write_cfg(FE | FI, 8'd2, 5'd5, 4'b0011);
        run_xfer(32'h2D, 32'h15, 6);
        idle_chk(2);

        write_cfg(FE | FI | FOFF, 8'd0, 5'd3, 4'b1111);
        run_xfer(32'h9, 32'h6, -1);
        idle_chk(1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule